// File: doc/BRIEF.md
# Write-Freeze Allocation Buffer Controller

This block sits on the memory side of a cache data array and owns two memory cycle buffers. Each buffer holds one 256-bit line (four 64-bit beats) and a per-byte valid mask. Normally every end-of-cycle strobe retires the buffer in use and moves to the other one. Moving to a buffer clears that buffer's mask.

A processor write can be turned into an allocation without performing the memory write. To do this, the freeze input is asserted together with the allocate-request and cacheable-return inputs at the moment the write cycle ends. The controller then keeps the same buffer. The four beats of the following line fill are merged around the bytes that the write left behind. The completed line is reported as modified, because memory never received the write.

Two sampling modes are supported, chosen by a mode select. In clocked mode the strobe and its qualifiers are taken at the rising clock edge where the strobe is low. In strobed mode the strobe is treated as asynchronous. It passes through a two-flop synchronizer, and its falling edge is detected in the system clock domain.

Top module: `wfab_top`

## Requirements
- R1: After reset, `buf_sel` is 0 and both `line_vld` and `line_mod` are 0.
- R2: An end-of-cycle event without an accepted freeze moves `buf_sel` to the other buffer. In clocked mode the change is visible after the same rising edge at which `eoc_n` is sampled low.
- R3: A freeze is accepted only when, at the event, `frz_n`, `alloc_n` and `cach_n` are all low and `cyc_wr` is high. An accepted freeze leaves `buf_sel` unchanged.
- R4: When `alloc_n` or `cach_n` is high at the event, a low `frz_n` has no effect: the buffer switches and the following line has `line_mod` = 0.
- R5: `frz_n` matters only at an end-of-cycle event. Holding it low during write beats or fill beats changes neither `buf_sel` nor the line result.
- R6: After an accepted freeze, write beat b with enable bit k set supplies line byte 8b+k, at `line_data[8*(8b+k)+:8]`. Every byte that was not written takes fill beat b lane k. Fill beat n is the n-th `fill_vld` cycle (counted from 0), and it covers `line_data[64n+:64]`.
- R7: `line_mod` is 1 for a line completed by a frozen-write allocation and 0 for any other line.
- R8: After a buffer switch the new buffer's mask is cleared, so the next line equals the fill data alone, even if writes were made before the switch.
- R9: In strobed mode, if `eoc_n` falls before rising edge k, the qualifiers are taken at edge k and `buf_sel` updates after edge k+2. A strobe that is held low for several cycles counts as one event.
- R10: `line_vld` is high for exactly the one cycle after the edge that takes the fourth fill beat. `line_data` and `line_mod` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobed_mode | input | 1 | 1 = strobed sampling through the synchronizer, 0 = clocked sampling |
| eoc_n | input | 1 | End-of-cycle strobe, active low |
| frz_n | input | 1 | Freeze request, active low (high when undriven) |
| alloc_n | input | 1 | Allocate request, active low |
| cach_n | input | 1 | Cacheable return, active low |
| cyc_wr | input | 1 | High while the ending memory cycle is a write |
| wr_vld | input | 1 | Write beat valid |
| wr_beat | input | 2 | Beat index of the write data |
| wr_data | input | 64 | Write data beat |
| wr_be | input | 8 | Byte enables of the write beat |
| fill_vld | input | 1 | Fill beat valid |
| fill_data | input | 64 | Fill data beat |
| buf_sel | output | 1 | Index of the active buffer |
| line_vld | output | 1 | One-cycle pulse: completed line available |
| line_data | output | 256 | Completed line |
| line_mod | output | 1 | Completed line must be held modified |

## Verification
The assertions take several things for granted. A write beat and a fill beat never arrive in the same cycle. The mode select does not change after reset. In strobed mode a falling strobe stays low for at least three clock cycles, with its qualifiers held steady. The stimulus tasks keep to these rules: they drive every input on the falling clock edge, issue writes and fills in separate phases, and choose the mode only while reset is held. In strobed mode the strobe is held low for four cycles and then left high for four cycles before the next phase.

// File: rtl/wfab_pkg.sv
package wfab_pkg;

    // Number of cycle buffers; switching walks through them in order.
    localparam int NUM_BUF = 2;

    // Qualified end-of-cycle sample, all fields active high.
    typedef struct packed {
        logic evt;    // end-of-cycle event in this cycle
        logic is_wr;  // ending cycle was a write
        logic frz;    // freeze requested
        logic alloc;  // allocation requested
        logic cach;   // line returned cacheable
    } eoc_smp_t;

endpackage

// File: rtl/wfab_eoc_sample.sv
module wfab_eoc_sample
    import wfab_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strobed,
    input  logic     eoc_n,
    input  logic     frz_n,
    input  logic     alloc_n,
    input  logic     cach_n,
    input  logic     cyc_wr,
    output eoc_smp_t smp
);

    localparam int CW = 4;

    typedef struct packed {
        logic [SYNC_STAGES:0]           eoc_sh;
        logic [SYNC_STAGES-1:0][CW-1:0] ctl_sh;
    } sync_t;

    sync_t         st_q, st_d;
    logic [CW-1:0] ctl_raw;
    logic          fall_evt;

    assign ctl_raw = {cyc_wr, ~frz_n, ~alloc_n, ~cach_n};

    always_comb begin
        st_d           = st_q;
        st_d.eoc_sh    = {st_q.eoc_sh[SYNC_STAGES-1:0], eoc_n};
        st_d.ctl_sh[0] = ctl_raw;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.ctl_sh[i] = st_q.ctl_sh[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.eoc_sh <= '1;
            st_q.ctl_sh <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Falling edge seen at the output of the synchronizer.
    assign fall_evt = st_q.eoc_sh[SYNC_STAGES] & ~st_q.eoc_sh[SYNC_STAGES-1];

    always_comb begin
        if (strobed) begin
            smp = {fall_evt, st_q.ctl_sh[SYNC_STAGES-1]};
        end else begin
            smp = {~eoc_n, ctl_raw};
        end
    end

    // R9
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobed && smp.evt) |=> !smp.evt);

endmodule

// File: rtl/wfab_buf_bank.sv
module wfab_buf_bank #(
    parameter int BEAT_W = 64,
    parameter int BEATS  = 4,
    parameter int NBUF   = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    wr_en,
    input  logic [((NBUF > 1) ? $clog2(NBUF) : 1)-1:0]   wr_buf,
    input  logic [((BEATS > 1) ? $clog2(BEATS) : 1)-1:0] wr_beat,
    input  logic [BEAT_W-1:0]                       wr_data,
    input  logic [BEAT_W/8-1:0]                     wr_be,
    input  logic                                    fill_en,
    input  logic [((NBUF > 1) ? $clog2(NBUF) : 1)-1:0]   fill_buf,
    input  logic [((BEATS > 1) ? $clog2(BEATS) : 1)-1:0] fill_beat,
    input  logic [BEAT_W-1:0]                       fill_data,
    input  logic                                    clr_en,
    input  logic [((NBUF > 1) ? $clog2(NBUF) : 1)-1:0]   clr_buf,
    input  logic [((NBUF > 1) ? $clog2(NBUF) : 1)-1:0]   rd_buf,
    output logic [BEATS*BEAT_W-1:0]                 rd_data
);

    localparam int BPB        = BEAT_W / 8;
    localparam int LINE_BYTES = BEATS * BPB;
    localparam int LINE_W     = BEATS * BEAT_W;
    localparam int BEAT_IW    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int BUF_IW     = (NBUF > 1) ? $clog2(NBUF) : 1;

    typedef struct packed {
        logic [LINE_W-1:0]     data;
        logic [LINE_BYTES-1:0] mask;
    } buf_t;

    logic [NBUF-1:0][LINE_W-1:0] data_all;

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        buf_t st_q, st_d;
        logic hit_wr, hit_fill, hit_clr;

        assign hit_wr   = wr_en   && (wr_buf   == BUF_IW'(g));
        assign hit_fill = fill_en && (fill_buf == BUF_IW'(g));
        assign hit_clr  = clr_en  && (clr_buf  == BUF_IW'(g));

        always_comb begin
            st_d = st_q;
            for (int y = 0; y < LINE_BYTES; y++) begin
                if (hit_wr && (wr_beat == BEAT_IW'(y / BPB)) && wr_be[y % BPB]) begin
                    st_d.data[8*y +: 8] = wr_data[8*(y % BPB) +: 8];
                    st_d.mask[y]        = 1'b1;
                end else if (hit_fill && (fill_beat == BEAT_IW'(y / BPB)) && !st_q.mask[y]) begin
                    st_d.data[8*y +: 8] = fill_data[8*(y % BPB) +: 8];
                end
            end
            if (hit_clr) begin
                st_d.mask = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign data_all[g] = st_q.data;
    end

    assign rd_data = data_all[rd_buf];

    // R6
    wr_fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && fill_en && (wr_buf == fill_buf)));

    // R8
    clr_fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_en && fill_en && (clr_buf == fill_buf)));

endmodule

// File: rtl/wfab_top.sv
module wfab_top
    import wfab_pkg::*;
#(
    parameter int BEAT_W      = 64,
    parameter int BEATS       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobed_mode,
    input  logic                    eoc_n,
    input  logic                    frz_n,
    input  logic                    alloc_n,
    input  logic                    cach_n,
    input  logic                    cyc_wr,
    input  logic                    wr_vld,
    input  logic [1:0]              wr_beat,
    input  logic [63:0]             wr_data,
    input  logic [7:0]              wr_be,
    input  logic                    fill_vld,
    input  logic [63:0]             fill_data,
    output logic                    buf_sel,
    output logic                    line_vld,
    output logic [255:0]            line_data,
    output logic                    line_mod
);

    localparam int BEAT_IW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int BUF_IW  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
    localparam int LINE_W  = BEATS * BEAT_W;

    typedef struct packed {
        logic [BUF_IW-1:0]  sel;
        logic [BEAT_IW-1:0] beat;
        logic               frozen;
        logic               line_vld;
        logic               line_mod;
        logic [BUF_IW-1:0]  done_buf;
    } ctl_t;

    ctl_t              st_q, st_d;
    eoc_smp_t          smp;
    logic              acc;
    logic              clr_en;
    logic [BUF_IW-1:0] sel_nx;
    logic [LINE_W-1:0] rd_line;

    wfab_eoc_sample #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sample_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobed (strobed_mode),
        .eoc_n   (eoc_n),
        .frz_n   (frz_n),
        .alloc_n (alloc_n),
        .cach_n  (cach_n),
        .cyc_wr  (cyc_wr),
        .smp     (smp)
    );

    assign acc    = smp.evt & smp.is_wr & smp.frz & smp.alloc & smp.cach;
    assign clr_en = smp.evt & ~acc;
    assign sel_nx = (st_q.sel == BUF_IW'(NUM_BUF - 1)) ? '0 : st_q.sel + 1'b1;

    always_comb begin
        st_d          = st_q;
        st_d.line_vld = 1'b0;
        if (fill_vld) begin
            st_d.beat = st_q.beat + 1'b1;
            if (st_q.beat == BEAT_IW'(BEATS - 1)) begin
                st_d.beat     = '0;
                st_d.line_vld = 1'b1;
                st_d.line_mod = st_q.frozen;
                st_d.done_buf = st_q.sel;
                st_d.frozen   = 1'b0;
            end
        end
        if (smp.evt) begin
            if (acc) begin
                st_d.frozen = 1'b1;
            end else begin
                st_d.sel    = sel_nx;
                st_d.frozen = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    wfab_buf_bank #(
        .BEAT_W (BEAT_W),
        .BEATS  (BEATS),
        .NBUF   (NUM_BUF)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_vld),
        .wr_buf    (st_q.sel),
        .wr_beat   (BEAT_IW'(wr_beat)),
        .wr_data   (wr_data),
        .wr_be     (wr_be),
        .fill_en   (fill_vld),
        .fill_buf  (st_q.sel),
        .fill_beat (st_q.beat),
        .fill_data (fill_data),
        .clr_en    (clr_en),
        .clr_buf   (sel_nx),
        .rd_buf    (st_q.done_buf),
        .rd_data   (rd_line)
    );

    assign buf_sel   = st_q.sel[0];
    assign line_vld  = st_q.line_vld;
    assign line_mod  = st_q.line_mod;
    assign line_data = rd_line;

    // R3
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> $stable(buf_sel));

    // R2
    switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp.evt && !acc) |=> (buf_sel != $past(buf_sel)));

    // R10
    line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_vld |=> !line_vld);

    // R10
    line_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_vld) |-> $past(fill_vld));

    // R6
    io_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_vld && fill_vld));

endmodule

// File: tb/wfab_top_tb_top.sv
module wfab_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strobed_mode = 1'b0;
    logic         eoc_n = 1'b1;
    logic         frz_n = 1'b1;
    logic         alloc_n = 1'b1;
    logic         cach_n = 1'b1;
    logic         cyc_wr = 1'b0;
    logic         wr_vld = 1'b0;
    logic [1:0]   wr_beat = '0;
    logic [63:0]  wr_data = '0;
    logic [7:0]   wr_be = '0;
    logic         fill_vld = 1'b0;
    logic [63:0]  fill_data = '0;
    logic         buf_sel;
    logic         line_vld;
    logic [255:0] line_data;
    logic         line_mod;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic exp_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    wfab_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobed_mode (strobed_mode),
        .eoc_n        (eoc_n),
        .frz_n        (frz_n),
        .alloc_n      (alloc_n),
        .cach_n       (cach_n),
        .cyc_wr       (cyc_wr),
        .wr_vld       (wr_vld),
        .wr_beat      (wr_beat),
        .wr_data      (wr_data),
        .wr_be        (wr_be),
        .fill_vld     (fill_vld),
        .fill_data    (fill_data),
        .buf_sel      (buf_sel),
        .line_vld     (line_vld),
        .line_data    (line_data),
        .line_mod     (line_mod)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wbyte(int s, int b, int k);
        return 8'((s * 29 + b * 8 + k) * 7 + 3);
    endfunction

    function automatic logic [7:0] fbyte(int s, int b, int k);
        return ~8'((s * 13 + b * 8 + k) * 5 + 1);
    endfunction

    function automatic logic [7:0] wmask(int s, int b);
        return 8'(s * 53 + b * 91 + 17);
    endfunction

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n        = 1'b0;
        strobed_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_sel = 1'b0;
        // R1
        chk("R1 buf_sel", 256'(buf_sel), 256'(0));
        chk("R1 line_vld", 256'(line_vld), 256'(0));
        chk("R1 line_mod", 256'(line_mod), 256'(0));
    endtask

    // Issues one end-of-cycle strobe with the given qualifier levels.
    task automatic do_eoc(input logic wr, input logic f_n, input logic a_n,
                          input logic c_n, input logic accept, input string req);
        logic old;
        old = exp_sel;
        if (!accept) exp_sel = ~exp_sel;
        eoc_n   = 1'b0;
        cyc_wr  = wr;
        frz_n   = f_n;
        alloc_n = a_n;
        cach_n  = c_n;
        if (strobed_mode) begin
            @(negedge clk);
            chk("R9 no early update k", 256'(buf_sel), 256'(old));
            @(negedge clk);
            chk("R9 no early update k+1", 256'(buf_sel), 256'(old));
            @(negedge clk);
            chk(req, 256'(buf_sel), 256'(exp_sel));
            @(negedge clk);
            eoc_n = 1'b1; cyc_wr = 1'b0; frz_n = 1'b1; alloc_n = 1'b1; cach_n = 1'b1;
            repeat (4) @(negedge clk);
            chk("R9 single event per strobe", 256'(buf_sel), 256'(exp_sel));
        end else begin
            @(negedge clk);
            chk(req, 256'(buf_sel), 256'(exp_sel));
            eoc_n = 1'b1; cyc_wr = 1'b0; frz_n = 1'b1; alloc_n = 1'b1; cach_n = 1'b1;
        end
    endtask

    task automatic run_scn(input int s);
        logic         wr, f_n, a_n, c_n, accept;
        logic [255:0] exp_line;
        string        tag;
        wr     = (s < 8);
        f_n    = s[0];
        a_n    = s[1];
        c_n    = s[2];
        accept = wr && (s[2:0] == 3'b000);
        if (accept)          tag = "R3 freeze keeps buffer";
        else if (!f_n && wr) tag = "R4 freeze ignored, switch";
        else if (!f_n)       tag = "R3 freeze on non-write ignored";
        else                 tag = "R2 normal switch";

        // Write beats with frz_n held low outside any event (R5).
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            wr_vld  = 1'b1;
            wr_beat = 2'(b);
            wr_be   = wmask(s, b);
            for (int k = 0; k < 8; k++) wr_data[8*k +: 8] = wbyte(s, b, k);
            frz_n   = 1'b0;
        end
        @(negedge clk);
        wr_vld = 1'b0;
        frz_n  = 1'b1;
        chk("R5 freeze outside event", 256'(buf_sel), 256'(exp_sel));

        do_eoc(wr, f_n, a_n, c_n, accept, tag);

        // Expected merged line.
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < 8; k++) begin
                if (accept && wmask(s, b)[k]) exp_line[64*b + 8*k +: 8] = wbyte(s, b, k);
                else                          exp_line[64*b + 8*k +: 8] = fbyte(s, b, k);
            end
        end

        // Fill beats, again with frz_n low (R5).
        for (int b = 0; b < 4; b++) begin
            fill_vld = 1'b1;
            frz_n    = 1'b0;
            for (int k = 0; k < 8; k++) fill_data[8*k +: 8] = fbyte(s, b, k);
            @(negedge clk);
        end
        fill_vld = 1'b0;
        frz_n    = 1'b1;
        chk("R10 line_vld after fourth beat", 256'(line_vld), 256'(1));
        chk(accept ? "R6 merged line" : "R8 fill-only line", line_data, exp_line);
        chk(accept ? "R7 modified" : "R4 R7 not modified", 256'(line_mod), 256'(accept));
        chk("R5 buffer kept during fill", 256'(buf_sel), 256'(exp_sel));
        @(negedge clk);
        chk("R10 line_vld one cycle", 256'(line_vld), 256'(0));

        // End of the fill cycle: a plain switch.
        do_eoc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2 switch after fill");
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            for (int s = 0; s < 9; s++) run_scn(s);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule